// File: doc/BRIEF.md
# Byte-Parallel CRC-8 Frame Checksum

This block computes an 8-bit cyclic redundancy check over the bytes of one serial frame. A frame is a 16-bit command word followed by zero or more 16-bit data words. The words are split into bytes, high byte first, and presented in order, one byte per clock. The result is the low byte of the status word that closes the frame. A sender transmits it, and a receiver compares it against the byte it received.

The generator polynomial is x^8 + x^4 + x^3 + x^2 + 1 (0x1D). The register starts from all ones. Bits are absorbed most significant first, with no reflection of input or output. The register is complemented on its way to the output.

A clear strobe reloads the seed at the start of each transfer. The same strobe is used when a transfer is aborted. The next-state logic handles a whole byte in one clock, and it is equivalent to eight serial shift steps.

Top module: `crc8_frame_check`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is loaded with the seed 0xFF, so `crc_out` reads 0x00 from the next cycle on.
- R2: With the polynomial 0x1D, MSB-first input and no reflection, the nine ASCII bytes "123456789" (0x31 to 0x39) fed after a clear give `crc_out` = 0x4B.
- R3: A byte presented with `byte_vld` high is absorbed at that rising edge, and its effect shows on `crc_out` in the following cycle. Back-to-back bytes are accepted on every clock.
- R4: For any register value and any byte, the one-clock update equals eight bit-serial steps. In each step, bit 7 of the data byte is taken first, feedback = reg[7] XOR data bit, and reg = (reg << 1) XOR (feedback ? 0x1D : 0x00).
- R5: `crc_clr` high with `byte_vld` low reloads the seed and discards any earlier accumulation, so `crc_out` reads 0x00 in the next cycle.
- R6: `crc_clr` and `byte_vld` both high in the same cycle make the presented byte the first byte of a new frame, absorbed from the seed 0xFF.
- R7: A cycle with both `crc_clr` and `byte_vld` low leaves `crc_out` unchanged, whatever `byte_in` carries.
- R8: `crc_out` is always the bitwise complement of the internal remainder. Over a full frame this covers every byte, command bytes included: command 0x8021, then data 0x1234 and 0xABCD, fed as 0x80, 0x21, 0x12, 0x34, 0xAB, 0xCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_clr | input | 1 | Start of transfer or abort; reloads the seed |
| byte_vld | input | 1 | `byte_in` holds a frame byte to absorb this cycle |
| byte_in | input | 8 | Frame byte, MSB first on the wire |
| crc_out | output | 8 | Complemented remainder over the bytes absorbed since the last clear |

## Verification
The bench sweeps all 256 byte values as the first byte of a frame that opens with a simultaneous clear. Each is followed by a dependent second byte. A design that let the clear win and dropped the byte, or that used the stale remainder instead of the seed, would give wrong values across the whole sweep.

A 600-byte unbroken stream is compared against a bit-serial model after every byte. This catches a wrong tap, a reversed bit order or a missing feedback term in the parallel logic.

Idle cycles with noise on the data bus expose a design that absorbs bytes without a valid. A clear in the middle of a frame exposes a design that keeps the old remainder. The standard check string pins down seed, polynomial and output complement together: getting any one of them wrong moves the result away from 0x4B.

// File: rtl/crc8_frame_pkg.sv
// Package crc8_frame_pkg
// Shared constants and a reference helper for the frame CRC.
// Assumes an 8-bit remainder; data width is set per instance.
package crc8_frame_pkg;

    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;
    localparam logic [CRC_W-1:0] CRC_XOUT = 8'hFF;

    typedef logic [CRC_W-1:0] crc_t;

    // Shift a remainder through n zero bits. Absorbing byte d into remainder r
    // equals zero_shift(r ^ d, 8) when the data width equals the CRC width.
    function automatic crc_t zero_shift(crc_t r, int n, crc_t poly);
        crc_t v;
        v = r;
        for (int k = 0; k < n; k++) begin
            v = v[CRC_W-1] ? ({v[CRC_W-2:0], 1'b0} ^ poly) : {v[CRC_W-2:0], 1'b0};
        end
        return v;
    endfunction

endpackage

// File: rtl/crc8_byte_step.sv
// Module crc8_byte_step
// Combinational next-state logic: absorbs DATA_W data bits, MSB first, into
// the remainder in one pass. Built as a chain of DATA_W serial shift stages.
// Assumes CRC_W >= 2. Holds no state.
module crc8_byte_step #(
    parameter int CRC_W  = 8,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h1D
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_next
);

    logic [DATA_W:0][CRC_W-1:0] chain;

    assign chain[0] = crc_in;

    // One serial division step per data bit, MSB of the data entering first.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][CRC_W-1] ^ data_in[DATA_W-1-i];
        assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_next = chain[DATA_W];

endmodule

// File: rtl/crc8_accum.sv
// Module crc8_accum
// Holds the running remainder. It selects the base for the next byte (the
// seed on a clear, the held value otherwise) and captures the step result
// when a byte is valid. Assumes an external step block maps base_o/data to
// step_i combinationally.
module crc8_accum #(
    parameter int CRC_W  = 8,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h1D,
    parameter logic [CRC_W-1:0] SEED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              vld,
    input  logic [DATA_W-1:0] data,
    input  logic [CRC_W-1:0]  step_i,
    output logic [CRC_W-1:0]  base_o,
    output logic [CRC_W-1:0]  crc_q
);

    // Base for this cycle's byte: a clear restarts from the seed.
    always_comb begin
        base_o = clr ? SEED : crc_q;
    end

    // Remainder register: reset/clear to seed, absorb on valid, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (vld) begin
            crc_q <= step_i;
        end else if (clr) begin
            crc_q <= SEED;
        end
    end

    AST_RESET_SEED: assert property (@(posedge clk)
        !rst_n |=> (crc_q == SEED)); // R1

    AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !vld) |=> (crc_q == SEED)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vld) |=> $stable(crc_q)); // R7

    if (DATA_W == CRC_W) begin : g_lin
        AST_BYTE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (vld && !clr) |=> (crc_q == crc8_frame_pkg::zero_shift(
                $past(crc_q) ^ $past(data), DATA_W, POLY))); // R4
        AST_CLR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
            (vld && clr) |=> (crc_q == crc8_frame_pkg::zero_shift(
                SEED ^ $past(data), DATA_W, POLY))); // R6
    end

endmodule

// File: rtl/crc8_frame_check.sv
// Module crc8_frame_check
// Top of the frame CRC. Bytes of a frame (command word first, each word high
// byte first) enter one per clock; crc_out is the complemented remainder.
// Assumes the framing logic outside issues crc_clr at transfer start or abort.
module crc8_frame_check #(
    parameter int CRC_W  = crc8_frame_pkg::CRC_W,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = crc8_frame_pkg::CRC_POLY,
    parameter logic [CRC_W-1:0] SEED = crc8_frame_pkg::CRC_SEED,
    parameter logic [CRC_W-1:0] XOUT = crc8_frame_pkg::CRC_XOUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_clr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] stepped;
    logic [CRC_W-1:0] rem_q;

    crc8_accum #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY),
        .SEED   (SEED)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .vld    (byte_vld),
        .data   (byte_in),
        .step_i (stepped),
        .base_o (base),
        .crc_q  (rem_q)
    );

    crc8_byte_step #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_step (
        .crc_in   (base),
        .data_in  (byte_in),
        .crc_next (stepped)
    );

    // Output complement of the held remainder.
    always_comb begin
        crc_out = rem_q ^ XOUT;
    end

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_clr && !byte_vld) |=> $stable(crc_out)); // R7

    AST_OUT_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_clr && !byte_vld) |=> (crc_out == (SEED ^ XOUT))); // R8

endmodule

// File: tb/sim_crc8_frame_check.sv
`timescale 1ns/1ps
module sim_crc8_frame_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_clr = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] crc_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    crc8_frame_check u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .crc_clr  (crc_clr),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .crc_out  (crc_out)
    );

    // Bit-serial reference: one byte, MSB first, poly 0x1D.
    function automatic logic [7:0] ref_byte(logic [7:0] r, logic [7:0] d);
        logic [7:0] v;
        logic fb;
        v = r;
        for (int k = 7; k >= 0; k--) begin
            fb = v[7] ^ d[k];
            v = {v[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return v;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; return at the next falling edge.
    task automatic cyc(logic c, logic v, logic [7:0] d);
        crc_clr = c;
        byte_vld = v;
        byte_in = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rem;
        logic [7:0] held;
        logic [7:0] frame [6];
        frame = '{8'h80, 8'h21, 8'h12, 8'h34, 8'hAB, 8'hCD};

        @(negedge clk);
        @(negedge clk);
        check("R1 reset", crc_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release", crc_out, 8'h00);

        // R2: standard check string after a clear.
        cyc(1, 0, 8'h00);
        rem = 8'hFF;
        for (int i = 0; i < 9; i++) begin
            cyc(0, 1, 8'h31 + 8'(i));
            rem = ref_byte(rem, 8'h31 + 8'(i));
        end
        check("R2 check string", crc_out, 8'h4B);
        check("R2 model agrees", ~rem, 8'h4B);

        // R6/R3/R7/R5: exhaustive first byte with clear in the same cycle.
        for (int b = 0; b < 256; b++) begin
            cyc(1, 1, 8'(b));
            rem = ref_byte(8'hFF, 8'(b));
            check("R6 clr+byte", crc_out, ~rem);
            cyc(0, 1, 8'(b * 37 + 11));
            rem = ref_byte(rem, 8'(b * 37 + 11));
            check("R3 second byte", crc_out, ~rem);
            held = crc_out;
            cyc(0, 0, 8'(~b));
            check("R7 idle hold", crc_out, held);
            cyc(1, 0, 8'(b));
            check("R5 clear", crc_out, 8'h00);
        end

        // R4: long stream, checked after every byte.
        rem = 8'hFF;
        for (int i = 0; i < 600; i++) begin
            cyc(0, 1, 8'(i * 73 + 5));
            rem = ref_byte(rem, 8'(i * 73 + 5));
            check("R4 stream", crc_out, ~rem);
        end

        // R5/R8: abort mid-frame, then a full frame with command bytes.
        cyc(1, 0, 8'h00);
        for (int i = 0; i < 3; i++) cyc(0, 1, frame[i]);
        cyc(1, 0, 8'h00);
        check("R5 abort", crc_out, 8'h00);
        rem = 8'hFF;
        for (int i = 0; i < 6; i++) begin
            cyc(0, 1, frame[i]);
            rem = ref_byte(rem, frame[i]);
        end
        check("R8 full frame", crc_out, ~rem);

        // R1: reset in the middle of activity.
        cyc(0, 1, 8'h5A);
        rst_n = 1'b0;
        cyc(0, 1, 8'hC3);
        check("R1 mid-run reset", crc_out, 8'h00);
        rst_n = 1'b1;
        cyc(0, 0, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule